// File: doc/BRIEF.md
# Region Access History Entry

This block holds the access record for one aligned 16 KB region of memory. The region is split into 256 blocks of 64 bytes, and each block has a two-bit state. The entry also holds the region tag, a 4-bit access counter, a saturating idle timer and a 6-bit recency rank that an outer set-replacement scheme owns. A lookup address is decoded at all times. The entry reports whether its tag matches and whether the addressed block has already been touched. It also brings out the state of that block and the whole 512-bit map, so that a stream or prefetch engine next to it can scan the map.

The control path raises one of three operations on a clock edge. A re-tag claims the entry for a new region and wipes its history. An update writes a new state into the addressed block, but only when the tag matches. A housekeeping tick ages the idle timer. The counter and the timer are coupled: when the access counter wraps, it drops back to eight and the timer is halved. The recent access rate is kept this way without growing either field.

Top module: `region_map_entry`

## Requirements
- R1: The lookup address splits into tag = bits [31:14] (18 bits), block index = bits [13:6] (0 to 255), and offset = bits [5:0]. The offset has no effect on any output.
- R2: `tagHit` is 1 in the same cycle exactly when the tag bits of `lookupAddr` equal the stored tag.
- R3: State code 0 means the block was never touched. `seenHit` = tagHit and indexed state ≠ 0. `freshHit` = tagHit and indexed state = 0. `slotState` shows the indexed state.
- R4: When `updEn` is high and the tag matches, the indexed block takes `updState` at the next edge. When the tag misses, the map, the counter and the timer are left unchanged.
- R5: Each update with a tag match raises the access counter by one while it is below 15. An update with a match at 15 sets it to 8.
- R6: In the cycle the counter wraps from 15 to 8, the idle timer is shifted right by one. A tick in the same cycle is then applied to the halved value.
- R7: Each `tick` raises the idle timer by one, and the timer holds at 65536.
- R8: `retagEn` loads the tag from `lookupAddr`, sets all 256 states to 0, and clears the counter and the timer. It takes priority over an update or a tick in the same cycle.
- R9: After reset the tag, map, counter, timer and rank are all zero.
- R10: `lruWrEn` loads `lruIn` into the rank at the next edge. Otherwise the rank holds.
- R11: `mapOut[2*i+1:2*i]` is the state of block i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupAddr | input | 32 | Address for lookup, update and re-tag |
| retagEn | input | 1 | Claim entry for the region of lookupAddr |
| updEn | input | 1 | Write updState into the addressed block |
| updState | input | 2 | New block state |
| tick | input | 1 | Housekeeping tick for the idle timer |
| lruWrEn | input | 1 | Load the recency rank |
| lruIn | input | 6 | New recency rank |
| tagHit | output | 1 | Stored tag matches lookupAddr |
| seenHit | output | 1 | Tag match and block already touched |
| freshHit | output | 1 | Tag match and block untouched |
| slotState | output | 2 | State of the addressed block |
| mapOut | output | 512 | Whole block-state map |
| tagOut | output | 18 | Stored tag |
| accessCnt | output | 4 | Access counter |
| idleTimer | output | 17 | Idle timer |
| lruRank | output | 6 | Recency rank |

## Verification
The hit flags and the indexed state come from stored state through logic alone. They are due in the same cycle as the lookup address, so the bench changes `lookupAddr` between edges and samples a nanosecond later. Updates, re-tags, ticks and rank writes go through one register stage. The bench drives them on a falling edge and checks the map, counter, timer and rank at the next falling edge, after exactly one rising edge. The sweep covers every one of the 256 blocks, and the counter wraps many times with ticks mixed in.

// File: rtl/rme_pkg.sv
package rme_pkg;
  typedef enum logic [1:0] {
    SLOT_UNTOUCHED  = 2'd0,
    SLOT_PREFETCHED = 2'd1,
    SLOT_DEMANDED   = 2'd2,
    SLOT_CONFIRMED  = 2'd3
  } slotState_e;

  typedef struct packed {
    logic clearAll;
    logic loadTag;
    logic writeSlot;
    logic bumpCnt;
  } mapStrobe_t;
endpackage

// File: rtl/rme_datapath.sv
module rme_datapath
  import rme_pkg::*;
#(
  parameter int TAG_W = 18,
  parameter int IDX_W = 8,
  localparam int SLOTS = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mapStrobe_t           strobe,
  input  logic [TAG_W-1:0]     lookupTag,
  input  logic [IDX_W-1:0]     slotIdx,
  input  logic [1:0]           wrState,
  output logic                 tagHit,
  output logic [1:0]           slotState,
  output logic [2*SLOTS-1:0]   mapOut,
  output logic [TAG_W-1:0]     tagOut
);
  logic [TAG_W-1:0] tagQ;
  logic [1:0]       slotQ [SLOTS];

  always_ff @(posedge clk) begin
    if (!rstN)               tagQ <= '0;
    else if (strobe.loadTag) tagQ <= lookupTag;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll)
        slotQ[g] <= SLOT_UNTOUCHED;
      else if (strobe.writeSlot && (slotIdx == IDX_W'(g)))
        slotQ[g] <= wrState;
    end
    assign mapOut[2*g +: 2] = slotQ[g];
  end

  assign tagHit    = (tagQ == lookupTag);
  assign slotState = slotQ[slotIdx];
  assign tagOut    = tagQ;
endmodule

// File: rtl/rme_control.sv
module rme_control
  import rme_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int TMR_MAX = 65536,
  parameter int LRU_W   = 6,
  localparam int TMR_W  = $clog2(TMR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retagEn,
  input  logic             updEn,
  input  logic             tick,
  input  logic             tagHit,
  input  logic             lruWrEn,
  input  logic [LRU_W-1:0] lruIn,
  output mapStrobe_t       strobe,
  output logic [CNT_W-1:0] accessCnt,
  output logic [TMR_W-1:0] idleTimer,
  output logic [LRU_W-1:0] lruRank
);
  localparam logic [CNT_W-1:0] CNT_TOP    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(1 << (CNT_W - 1));
  localparam logic [TMR_W-1:0] TMR_TOP    = TMR_W'(TMR_MAX);

  logic [CNT_W-1:0] cntQ;
  logic [TMR_W-1:0] tmrQ, tmrHalved;
  logic [LRU_W-1:0] lruQ;
  logic             wrapNow;

  always_comb begin
    strobe.clearAll  = retagEn;
    strobe.loadTag   = retagEn;
    strobe.writeSlot = updEn && tagHit && !retagEn;
    strobe.bumpCnt   = updEn && tagHit && !retagEn;
  end

  assign wrapNow   = strobe.bumpCnt && (cntQ == CNT_TOP);
  assign tmrHalved = wrapNow ? (tmrQ >> 1) : tmrQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      cntQ <= '0;
      tmrQ <= '0;
    end else begin
      if (wrapNow)             cntQ <= CNT_RELOAD;
      else if (strobe.bumpCnt) cntQ <= cntQ + 1'b1;
      if (tick && (tmrHalved < TMR_TOP)) tmrQ <= tmrHalved + 1'b1;
      else                               tmrQ <= tmrHalved;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        lruQ <= '0;
    else if (lruWrEn) lruQ <= lruIn;
  end

  assign accessCnt = cntQ;
  assign idleTimer = tmrQ;
  assign lruRank   = lruQ;
endmodule

// File: rtl/region_map_entry.sv
module region_map_entry
  import rme_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_BITS = 6,
  parameter int IDX_W    = 8,
  parameter int CNT_W    = 4,
  parameter int TMR_MAX  = 65536,
  parameter int LRU_W    = 6,
  localparam int TAG_W   = ADDR_W - IDX_W - BLK_BITS,
  localparam int SLOTS   = 1 << IDX_W,
  localparam int TMR_W   = $clog2(TMR_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   lookupAddr,
  input  logic                retagEn,
  input  logic                updEn,
  input  logic [1:0]          updState,
  input  logic                tick,
  input  logic                lruWrEn,
  input  logic [LRU_W-1:0]    lruIn,
  output logic                tagHit,
  output logic                seenHit,
  output logic                freshHit,
  output logic [1:0]          slotState,
  output logic [2*SLOTS-1:0]  mapOut,
  output logic [TAG_W-1:0]    tagOut,
  output logic [CNT_W-1:0]    accessCnt,
  output logic [TMR_W-1:0]    idleTimer,
  output logic [LRU_W-1:0]    lruRank
);
  logic [TAG_W-1:0] lookupTag;
  logic [IDX_W-1:0] slotIdx;
  logic             unusedOffset;
  mapStrobe_t       strobe;

  assign lookupTag    = lookupAddr[ADDR_W-1 -: TAG_W];
  assign slotIdx      = lookupAddr[BLK_BITS +: IDX_W];
  assign unusedOffset = ^lookupAddr[BLK_BITS-1:0];

  rme_control #(.CNT_W(CNT_W), .TMR_MAX(TMR_MAX), .LRU_W(LRU_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .retagEn(retagEn), .updEn(updEn), .tick(tick),
    .tagHit(tagHit), .lruWrEn(lruWrEn), .lruIn(lruIn), .strobe(strobe),
    .accessCnt(accessCnt), .idleTimer(idleTimer), .lruRank(lruRank)
  );

  rme_datapath #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupTag(lookupTag),
    .slotIdx(slotIdx), .wrState(updState), .tagHit(tagHit),
    .slotState(slotState), .mapOut(mapOut), .tagOut(tagOut)
  );

  assign seenHit  = tagHit && (slotState != SLOT_UNTOUCHED);
  assign freshHit = tagHit && (slotState == SLOT_UNTOUCHED);
endmodule

// File: rtl/region_map_entry_chk.sv
module region_map_entry_chk #(
  parameter int CNT_W   = 4,
  parameter int TMR_MAX = 65536,
  parameter int SLOTS   = 256,
  localparam int TMR_W  = $clog2(TMR_MAX + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               retagEn,
  input logic               updEn,
  input logic               tick,
  input logic               tagHit,
  input logic               seenHit,
  input logic               freshHit,
  input logic [2*SLOTS-1:0] mapOut,
  input logic [CNT_W-1:0]   accessCnt,
  input logic [TMR_W-1:0]   idleTimer
);
  localparam logic [CNT_W-1:0] CNT_TOP    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(1 << (CNT_W - 1));

  // R3: exactly one of the two block flags accompanies a tag hit
  a_r3_flags_split: assert property (@(posedge clk) disable iff (!rstN)
    tagHit == (seenHit ^ freshHit));

  // R4: an update that misses the tag leaves history untouched
  a_r4_miss_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && !tagHit && !retagEn && !tick) |=>
      ($stable(mapOut) && $stable(accessCnt) && $stable(idleTimer)));

  // R5: counter wraps from its top value to the reload value
  a_r5_counter_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && tagHit && !retagEn && accessCnt == CNT_TOP) |=> accessCnt == CNT_RELOAD);

  // R6: timer is halved on a wrap without tick
  a_r6_timer_halve: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && tagHit && !retagEn && !tick && accessCnt == CNT_TOP) |=>
      idleTimer == ($past(idleTimer) >> 1));

  // R7: timer never exceeds its ceiling
  a_r7_timer_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    idleTimer <= TMR_W'(TMR_MAX));

  // R8: re-tag wipes the history
  a_r8_retag_clear: assert property (@(posedge clk) disable iff (!rstN)
    retagEn |=> (mapOut == '0 && accessCnt == '0 && idleTimer == '0));
endmodule

bind region_map_entry region_map_entry_chk #(
  .CNT_W(CNT_W), .TMR_MAX(TMR_MAX), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rstN(rstN), .retagEn(retagEn), .updEn(updEn), .tick(tick),
  .tagHit(tagHit), .seenHit(seenHit), .freshHit(freshHit), .mapOut(mapOut),
  .accessCnt(accessCnt), .idleTimer(idleTimer)
);

// File: tb/region_map_entry_bench.sv
module region_map_entry_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  lookupAddr = '0;
  logic         retagEn = 1'b0, updEn = 1'b0, tick = 1'b0, lruWrEn = 1'b0;
  logic [1:0]   updState = '0;
  logic [5:0]   lruIn = '0;
  logic         tagHit, seenHit, freshHit;
  logic [1:0]   slotState;
  logic [511:0] mapOut;
  logic [17:0]  tagOut;
  logic [3:0]   accessCnt;
  logic [16:0]  idleTimer;
  logic [5:0]   lruRank;

  int checks = 0;
  int errors = 0;

  logic [1:0]  expMap [256];
  logic [17:0] expTag;
  int          expCnt, expTmr;
  logic [5:0]  expLru;

  always #5 clk = ~clk;

  region_map_entry u_region_map_entry (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .retagEn(retagEn),
    .updEn(updEn), .updState(updState), .tick(tick), .lruWrEn(lruWrEn),
    .lruIn(lruIn), .tagHit(tagHit), .seenHit(seenHit), .freshHit(freshHit),
    .slotState(slotState), .mapOut(mapOut), .tagOut(tagOut),
    .accessCnt(accessCnt), .idleTimer(idleTimer), .lruRank(lruRank)
  );

  function automatic logic [31:0] mkAddr(logic [17:0] t, logic [7:0] i, logic [5:0] o);
    return {t, i, o};
  endfunction

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    logic [511:0] packed_;
    for (int i = 0; i < 256; i++) packed_[2*i +: 2] = expMap[i];
    check({req, " R11 map"}, mapOut, packed_);
    check({req, " tag"}, 512'(tagOut), 512'(expTag));
    check({req, " R5 counter"}, 512'(accessCnt), 512'(expCnt));
    check({req, " R7 timer"}, 512'(idleTimer), 512'(expTmr));
    check({req, " R10 rank"}, 512'(lruRank), 512'(expLru));
  endtask

  task automatic checkLookup(string req, logic [31:0] a);
    logic hit;
    logic [1:0] st;
    lookupAddr = a;
    #1;
    hit = (a[31:14] == expTag);
    st  = expMap[a[13:6]];
    check({req, " R2 tagHit"}, 512'(tagHit), 512'(hit));
    check({req, " R3 seenHit"}, 512'(seenHit), 512'(hit && st != 2'd0));
    check({req, " R3 freshHit"}, 512'(freshHit), 512'(hit && st == 2'd0));
    check({req, " R3 slotState"}, 512'(slotState), 512'(st));
  endtask

  task automatic step(logic rt, logic up, logic [1:0] st, logic tk,
                      logic lw, logic [5:0] lv, logic [31:0] a);
    retagEn = rt; updEn = up; updState = st; tick = tk;
    lruWrEn = lw; lruIn = lv; lookupAddr = a;
    @(posedge clk);
    if (rt) begin
      expTag = a[31:14];
      for (int i = 0; i < 256; i++) expMap[i] = 2'd0;
      expCnt = 0; expTmr = 0;
    end else begin
      if (up && a[31:14] == expTag) begin
        expMap[a[13:6]] = st;
        if (expCnt >= 15) begin expCnt = 8; expTmr = expTmr / 2; end
        else expCnt++;
      end
      if (tk && expTmr < 65536) expTmr++;
    end
    if (lw) expLru = lv;
    @(negedge clk);
    retagEn = 0; updEn = 0; tick = 0; lruWrEn = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] tagA;
    logic [17:0] tagB;
    tagA = 18'h2A5C3;
    tagB = 18'h1F00E;
    for (int i = 0; i < 256; i++) expMap[i] = 2'd0;
    expTag = '0; expCnt = 0; expTmr = 0; expLru = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state, tag 0 region hits untouched blocks
    checkState("R9 reset");
    checkLookup("R9 reset lookup", mkAddr(18'h0, 8'd17, 6'd3));

    // R8: re-tag combined with update and tick; re-tag wins
    step(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 6'd0, mkAddr(tagA, 8'd5, 6'd0));
    checkState("R8 retag");

    // R1/R3/R4/R5/R6/R7: sweep every block, ticks interleaved
    for (int i = 0; i < 256; i++) begin
      logic [31:0] a;
      a = mkAddr(tagA, 8'(i), 6'((i * 7) % 64));
      checkLookup("R1 R3 pre-write", a);
      step(1'b0, 1'b1, 2'((i % 3) + 1), (i % 2) == 0, 1'b0, 6'd0, a);
      checkState("R4 R5 R6 sweep");
      checkLookup("R4 post-write", mkAddr(tagA, 8'(i), 6'(63 - (i % 64))));
    end

    // R4: update to a foreign tag is ignored
    step(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 6'd0, mkAddr(tagB, 8'd9, 6'd1));
    checkState("R4 miss ignored");
    checkLookup("R2 miss lookup", mkAddr(tagB, 8'd9, 6'd1));

    // R10: rank writes and hold
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 6'd45, mkAddr(tagA, 8'd0, 6'd0));
    checkState("R10 rank load");
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 6'd12, mkAddr(tagA, 8'd0, 6'd0));
    checkState("R10 rank hold");

    // R7: timer saturates at 65536
    step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 6'd0, mkAddr(tagB, 8'd0, 6'd0));
    tick = 1'b1;
    repeat (65540) @(posedge clk);
    expTmr = 65536;
    @(negedge clk);
    tick = 1'b0;
    checkState("R7 saturate");

    // R6: wrap with tick in same cycle halves then increments
    for (int i = 0; i < 15; i++)
      step(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 6'd0, mkAddr(tagB, 8'(i), 6'd0));
    checkState("R5 at top");
    step(1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 6'd0, mkAddr(tagB, 8'd200, 6'd0));
    checkState("R6 wrap with tick");
    check("R6 halved timer", 512'(idleTimer), 512'(32769));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule